// File: doc/BRIEF.md
# I2C Register-Access Slave Controller

This block is the target side of a two-wire serial bus. An external master uses it to reach a nine-entry register map that sits behind a small request port. The block samples SCL and SDA on the system clock and finds START, repeated START and STOP conditions on the resynchronised levels. It checks each identification byte against a fixed 4-bit prefix and three strap inputs. It loads an address byte into an internal pointer and then moves data bytes in either direction. The pointer advances after every byte and wraps from the top entry back to entry zero.

The block never drives SDA high. Its single output toward the pad is a pull-low enable, and the pad itself is an open-drain driver with an external pull-up. On the register side each accepted write byte gives a single-cycle write strobe with address and data. Each byte to be sent gives a single-cycle read strobe, and the register bank must return the data in the same cycle. A busy input from the bank blocks new transactions and refuses write data while a slow internal update is running.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the SDA pull-low enable is off and neither register strobe is asserted.
- R2: The slave ACKs an identification byte only when bits 7:4 equal 4'b1010 and bits 3:1 equal strap_i[2:0]. Bit 0 = 1 selects a read. On a mismatch the byte is left un-ACKed, and later bytes get no ACK and cause no strobe until the next START.
- R3: In a write (START, ID with bit 0 = 0, address byte, data bytes), the address byte and every data byte are ACKed. Each data byte, received MSB first on SCL rising edges, produces exactly one write strobe carrying the current pointer and that byte.
- R4: The pointer increments after each written byte, and the entry after 8 is 0.
- R5: In a read (ID with bit 0 = 1, usually after an address write and a repeated START), the slave sends the entry at the pointer MSB first and changes SDA only after SCL falling edges. It goes on to the next entry for as long as the master ACKs in the ninth clock. The pointer steps by one per byte sent and wraps from 8 to 0.
- R6: After a master NACK on a read byte, the slave releases SDA, issues no further read strobe, and waits for STOP or START.
- R7: An address byte of 9 or more is NACKed, and it leaves the pointer unchanged.
- R8: While busy_i is high, a START is not recognised, and a write data byte is NACKed without a write strobe.
- R9: A STOP returns the slave to idle with SDA released. The pull-low enable changes only while the synchronised SCL is low, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| strap_i | input | 3 | Pin-strapped low bits of the device identity |
| busy_i | input | 1 | Register bank busy with a slow update |
| sda_pull_o | output | 1 | Pull SDA low when high |
| reg_addr_o | output | 4 | Register pointer presented to the bank |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_re_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid in the strobe cycle |

## Verification
The in-line assertions check on every cycle several structural rules. The pull-low enable never moves while SCL is high, except at START or STOP. It stays off in the idle and waiting states. The pointer stays in range and wraps after a write to the top entry. A START under busy leaves the state alone. The bench scenarios are needed for the protocol-level behaviour: the ACK or NACK given to each byte, the order and contents of the write and read strobes against a queue of expected accesses, the bit values that appear on SDA during reads, and the pointer carried across a refused address or a refused write.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         NREG       = 9,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       busy_i,
  output logic       sda_pull_o,
  output logic [3:0] reg_addr_o,
  output logic       reg_we_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_re_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int AW = 4;
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  typedef enum logic [2:0] {S_IDLE, S_ID, S_ADDR, S_WR, S_RD, S_WAIT} st_t;

  st_t           state;
  logic [1:0]    scl_s, sda_s;
  logic          scl_q, sda_q;
  logic [3:0]    cnt;
  logic [7:0]    shreg, txsh;
  logic [AW-1:0] ptr;
  logic          pull;

  wire scl = scl_s[1];
  wire sda = sda_s[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda & ~busy_i;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire active   = (state == S_ID) || (state == S_ADDR) || (state == S_WR) || (state == S_RD);
  wire slot_beg = active & scl_fall & (cnt == 4'd8);
  wire slot_end = active & scl_fall & (cnt == 4'd9);
  wire id_ok    = shreg[7:1] == {DEV_PREFIX, strap_i};
  wire addr_ok  = 32'(shreg) < NREG;
  wire [AW-1:0] ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;

  assign sda_pull_o  = pull;
  assign reg_addr_o  = ptr;
  assign reg_wdata_o = shreg;
  assign reg_we_o    = slot_beg & (state == S_WR) & ~busy_i;
  assign reg_re_o    = slot_end & (state == S_RD) & ~shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      shreg <= '0;
      txsh  <= '0;
      ptr   <= '0;
      pull  <= 1'b0;
    end else if (start_c) begin
      state <= S_ID;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE;
      cnt   <= '0;
      pull  <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        shreg <= {shreg[6:0], sda};
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (state)
            S_ID: begin
              pull  <= id_ok;
              state <= !id_ok ? S_WAIT : (shreg[0] ? S_RD : S_ADDR);
            end
            S_ADDR: begin
              pull <= addr_ok;
              if (addr_ok) begin
                ptr   <= shreg[AW-1:0];
                state <= S_WR;
              end else state <= S_WAIT;
            end
            S_WR: begin
              pull <= ~busy_i;
              if (busy_i) state <= S_WAIT;
              else        ptr   <= ptr_next;
            end
            default: pull <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (state == S_RD && !shreg[0]) begin
            txsh <= reg_rdata_i;
            pull <= ~reg_rdata_i[7];
            ptr  <= ptr_next;
          end else begin
            pull <= 1'b0;
            if (state == S_RD) state <= S_WAIT;
          end
        end else if (cnt != 4'd0 && state == S_RD) begin
          pull <= ~txsh[6];
          txsh <= {txsh[6:0], 1'b0};
        end
      end
    end
  end

  a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pull != $past(pull)) |-> ($past(!scl) || $past(start_c || stop_c)));
  a_r6_released_when_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_WAIT) |-> !sda_pull_o);
  a_r4_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(reg_addr_o) < NREG);
  a_r4_wrap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_addr_o == LAST) |=> reg_addr_o == '0);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && scl && scl_q && sda_q && !sda) |=> $stable(state));
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb_top;
  localparam int H = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_pull, we, re;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [0:8];
  wire sda_line = m_sda & ~sda_pull;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int exp_wr[$];
  int exp_rd[$];

  always #4 clk = ~clk;

  i2c_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .sda_pull_o(sda_pull), .reg_addr_o(addr), .reg_we_o(we),
    .reg_wdata_o(wdata), .reg_re_o(re), .reg_rdata_i(rdata));

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  task automatic cmp(input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (we) begin
      if (exp_wr.size() == 0) cmp({addr, wdata}, 'hFFF, "R3 unexpected write");
      else cmp({addr, wdata}, exp_wr.pop_front(), "R3 write addr/data");
    end
    if (re) begin
      if (exp_rd.size() == 0) cmp(addr, 'hFF, "R5 unexpected read");
      else cmp(addr, exp_rd.pop_front(), "R5 read addr");
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    m_sda = 1; ticks(H); m_scl = 1; ticks(H); m_sda = 0; ticks(H); m_scl = 0; ticks(2);
  endtask

  task automatic stop_c();
    m_sda = 0; ticks(H); m_scl = 1; ticks(H); m_sda = 1; ticks(H);
    cmp(sda_pull, 0, "R9 released after stop");
  endtask

  task automatic send(input logic [7:0] b, input bit ack, input string what);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; ticks(H); m_scl = 1; ticks(H); m_scl = 0; ticks(2);
    end
    m_sda = 1; ticks(H);
    cmp(sda_pull, ack, what);
    m_scl = 1; ticks(H); m_scl = 0; ticks(2);
  endtask

  task automatic recv(input logic [7:0] e, input bit mack, input string what);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; ticks(H);
      cmp(sda_pull, !e[i], what);
      m_scl = 1; ticks(H); m_scl = 0; ticks(2);
    end
    m_sda = !mack; ticks(H);
    cmp(sda_pull, 0, "R6 released in master ack slot");
    m_scl = 1; ticks(H); m_scl = 0; ticks(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) mem[i] = 8'h30 + 8'(i);
    ticks(5);
    cmp(sda_pull, 0, "R1 reset pull");
    cmp(we, 0, "R1 reset write strobe");
    cmp(re, 0, "R1 reset read strobe");
    rst_n = 1; ticks(5);

    // R3 R4: write three bytes from 7, wrapping 8 -> 0
    exp_wr.push_back('h711); exp_wr.push_back('h822); exp_wr.push_back('h033);
    start_c();
    send(8'hAA, 1, "R2 id ack");
    send(8'h07, 1, "R3 addr ack");
    send(8'h11, 1, "R3 data ack");
    send(8'h22, 1, "R4 data ack at 8");
    send(8'h33, 1, "R4 data ack after wrap");
    stop_c();

    // R5 R6: read back across wrap, NACK on last
    exp_rd.push_back(7); exp_rd.push_back(8); exp_rd.push_back(0);
    start_c();
    send(8'hAA, 1, "R2 id ack");
    send(8'h07, 1, "R5 addr ack");
    start_c();
    send(8'hAB, 1, "R2 read id ack");
    recv(8'h11, 1, "R5 read entry 7");
    recv(8'h22, 1, "R5 read entry 8");
    recv(8'h33, 0, "R5 read entry 0 after wrap");
    ticks(H);
    cmp(sda_pull, 0, "R6 released after nack");
    stop_c();

    // R2: wrong strap bits
    start_c();
    send(8'hA2, 0, "R2 mismatched id nack");
    send(8'h00, 0, "R2 no ack until start");
    stop_c();

    // R7: out-of-range address keeps pointer (now 1)
    exp_rd.push_back(1);
    start_c();
    send(8'hAA, 1, "R2 id ack");
    send(8'h09, 0, "R7 addr 9 nack");
    start_c();
    send(8'hAB, 1, "R2 read id ack");
    recv(8'h31, 0, "R7 pointer unchanged read");
    stop_c();

    // R8: busy blocks START and write data
    busy = 1;
    start_c();
    send(8'hAA, 0, "R8 start ignored while busy");
    stop_c();
    busy = 0;
    start_c();
    send(8'hAA, 1, "R2 id ack");
    send(8'h02, 1, "R8 addr ack");
    busy = 1;
    send(8'h55, 0, "R8 data nack while busy");
    busy = 0;
    stop_c();
    exp_rd.push_back(2);
    start_c();
    send(8'hAA, 1, "R2 id ack");
    send(8'h02, 1, "R8 addr ack");
    start_c();
    send(8'hAB, 1, "R2 read id ack");
    recv(8'h32, 0, "R8 entry 2 unchanged");
    stop_c();

    ticks(20);
    cmp(exp_wr.size() + exp_rd.size(), 0, "R3 R5 all expected strobes seen");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule